// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a countdown watchdog that sits in a power-management register space and asks for a system reset when software stops servicing it. It counts a 32-bit value down by one on each pulse of a 32.768 kHz tick enable. A 50 ms window therefore needs a load of 1638. Software writes the count as two 16-bit halves, sets the run and reset-enable bits, and the block raises a reset request once the count runs out.

The load and control registers take writes only after a 16-bit unlock key has been written to the lock register. Any other value written there, including the key's bitwise inverse, locks the block again. Two module-enable inputs gate the block. The interface enable gates register access. The work enable gates counting.

Register access uses a plain single-cycle strobe. A write takes effect on the clock edge at which `bus_wr` is high. The read data is a combinational function of `bus_addr`. There is no back-pressure, because every access completes in one cycle.

Top module: `kl_wdt`

## Requirements
- R1: After reset the block is locked. The load halves and the control register read 0x0000, the lock register reads 0x0001, and `reset_req` is low.
- R2: Writing 0xE551 to the lock register (byte offset 0x20) unlocks the block, and the lock register then reads 0x0000. Writing any other 16-bit value there, the inverse 0x1AAE included, locks it, and the lock register then reads 0x0001.
- R3: While the block is locked, writes to the load halves and to the control register are ignored. Reads still return their current contents.
- R4: The count is 32 bits wide. Its low half is at offset 0x00 and its high half is at offset 0x04, so the count equals high·65536 + low.
- R5: The control register at offset 0x08 holds run on bit 1 and reset-enable on bit 3. Bit 2 is a new-load command that always reads back 0. All other bits read 0.
- R6: When run goes from 0 to 1, the counter loads from the load halves. Each later tick decrements it, and the request rises on the clock edge of the Nth tick when reset-enable is set. A load of 0 or 1 expires on the first tick.
- R7: Once raised, `reset_req` stays high until `rst_n`, even if run is cleared or the block is locked.
- R8: With reset-enable clear, expiry raises no request and the counter holds at zero. Setting reset-enable later raises the request on the next tick.
- R9: Ticks have no effect while `work_enable` is low.
- R10: While `intf_enable` is low, all writes are ignored (the lock register included) and `bus_rdata` reads 0x0000.
- R11: Writing the control register with bit 2 set reloads the counter from the load halves, so a running count restarts its full window.
- R12: Ticks have no effect while run is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle pulse at 32.768 kHz that advances the count |
| intf_enable | input | 1 | Module enable for the register interface |
| work_enable | input | 1 | Module enable for the counting logic |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| reset_req | output | 1 | Sticky system reset request |

## Verification
The assertions run on every cycle and check five things:
- a raised request never drops before reset;
- a request rises only on an enabled tick while run and reset-enable are set;
- a locked block or a disabled interface leaves the control and lock state unchanged;
- the count stays still when the work enable is low and nothing is written;
- the new-load bit never reads back as 1.

Other behaviour needs the bench's scenarios:
- the exact tick at which a given load expires, swept over small loads and one load that uses the high half;
- the unlock and relock key values;
- the reload restarting a partly spent window;
- expiry without reset-enable being armed afterwards.

// File: rtl/kl_wdt_pkg.sv
package kl_wdt_pkg;
  localparam int unsigned OFF_LOAD_LO = 8'h00;
  localparam int unsigned OFF_LOAD_HI = 8'h04;
  localparam int unsigned OFF_CTRL    = 8'h08;
  localparam int unsigned OFF_LOCK    = 8'h20;

  localparam int unsigned BIT_RUN   = 1;
  localparam int unsigned BIT_NEW   = 2;
  localparam int unsigned BIT_RSTEN = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LOAD_LO,
    SEL_LOAD_HI,
    SEL_CTRL,
    SEL_LOCK
  } reg_sel_e;
endpackage

// File: rtl/kl_wdt_lock.sv
module kl_wdt_lock #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_VAL = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic key_match;
  assign key_match = (wdata == KEY_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b1;
    else if (lock_wr) locked <= !key_match;
  end
endmodule

// File: rtl/kl_wdt_regs.sv
module kl_wdt_regs
  import kl_wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  load_val,
  output logic              run_q,
  output logic              rst_en_q,
  output logic              load_strobe
);
  logic [1:0][DATA_W-1:0] half_q;
  logic [1:0]             half_sel;

  assign half_sel[0] = (sel == SEL_LOAD_LO);
  assign half_sel[1] = (sel == SEL_LOAD_HI);

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                half_q[h] <= '0;
      else if (wr && half_sel[h]) half_q[h] <= wdata;
    end
  end

  assign load_val = half_q;

  logic ctl_wr;
  assign ctl_wr = wr && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
    end else if (ctl_wr) begin
      run_q    <= wdata[BIT_RUN];
      rst_en_q <= wdata[BIT_RSTEN];
    end
  end

  assign load_strobe = ctl_wr && (wdata[BIT_NEW] || (wdata[BIT_RUN] && !run_q));
endmodule

// File: rtl/kl_wdt_count.sv
module kl_wdt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_strobe,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             rst_en,
  input  logic             tick,
  input  logic             work_en,
  output logic [CNT_W-1:0] count,
  output logic             reset_req
);
  logic step, at_end, expire;

  assign step   = run && work_en && tick && !load_strobe;
  assign at_end = (count <= CNT_W'(1));
  assign expire = step && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (load_strobe)            count <= load_val;
    else if (step && count != '0)    count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 reset_req <= 1'b0;
    else if (expire && rst_en)  reset_req <= 1'b1;
  end
endmodule

// File: rtl/kl_wdt.sv
module kl_wdt
  import kl_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_VAL = 16'hE551,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              intf_enable,
  input  logic              work_enable,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  reg_sel_e         sel;
  logic             locked;
  logic             acc_wr, lock_wr, reg_wr;
  logic [CNT_W-1:0] load_val, count;
  logic             run_q, rst_en_q, load_strobe;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_LOAD_LO): sel = SEL_LOAD_LO;
      ADDR_W'(OFF_LOAD_HI): sel = SEL_LOAD_HI;
      ADDR_W'(OFF_CTRL):    sel = SEL_CTRL;
      ADDR_W'(OFF_LOCK):    sel = SEL_LOCK;
      default:              sel = SEL_NONE;
    endcase
  end

  assign acc_wr  = bus_wr && intf_enable;
  assign lock_wr = acc_wr && (sel == SEL_LOCK);
  assign reg_wr  = acc_wr && !locked;

  kl_wdt_lock #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_wr (lock_wr),
    .wdata   (bus_wdata),
    .locked  (locked)
  );

  kl_wdt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (reg_wr),
    .sel         (sel),
    .wdata       (bus_wdata),
    .load_val    (load_val),
    .run_q       (run_q),
    .rst_en_q    (rst_en_q),
    .load_strobe (load_strobe)
  );

  kl_wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_strobe (load_strobe),
    .load_val    (load_val),
    .run         (run_q),
    .rst_en      (rst_en_q),
    .tick        (tick_32k),
    .work_en     (work_enable),
    .count       (count),
    .reset_req   (reset_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (intf_enable) begin
      case (sel)
        SEL_LOAD_LO: bus_rdata = load_val[DATA_W-1:0];
        SEL_LOAD_HI: bus_rdata = load_val[CNT_W-1:DATA_W];
        SEL_CTRL: begin
          bus_rdata[BIT_RUN]   = run_q;
          bus_rdata[BIT_RSTEN] = rst_en_q;
        end
        SEL_LOCK:    bus_rdata[0] = locked;
        default:     bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kl_wdt_chk.sv
module kl_wdt_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_32k,
  input logic              intf_enable,
  input logic              work_enable,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              reset_req,
  input logic              locked,
  input logic              run_q,
  input logic              rst_en_q,
  input logic [CNT_W-1:0]  count
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(kl_wdt_pkg::OFF_CTRL);

  // R7
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  // R6
  req_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(tick_32k && work_enable && run_q && rst_en_q));

  // R3
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && intf_enable && bus_addr == A_CTRL)
      |=> ($stable(run_q) && $stable(rst_en_q)));

  // R10
  intf_off_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !intf_enable |=> $stable(locked));

  // R9
  work_off_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!work_enable && !bus_wr) |=> $stable(count));

  // R5
  new_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> !bus_rdata[kl_wdt_pkg::BIT_NEW]);
endmodule

bind kl_wdt kl_wdt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_32k    (tick_32k),
  .intf_enable (intf_enable),
  .work_enable (work_enable),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .reset_req   (reset_req),
  .locked      (locked),
  .run_q       (run_q),
  .rst_en_q    (rst_en_q),
  .count       (count)
);

// File: tb/tb_kl_wdt.sv
module tb_kl_wdt;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_CTL = 8'h08, A_LK = 8'h20;
  localparam logic [15:0] KEY = 16'hE551;

  logic clk = 1'b0, rst_n = 1'b0, tick_32k = 1'b0;
  logic intf_enable = 1'b1, work_enable = 1'b1, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic reset_req;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  kl_wdt dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .intf_enable(intf_enable),
    .work_enable(work_enable), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick_n(input int k);
    tick_32k = 1'b1;
    repeat (k) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic arm(input logic [31:0] ld, input logic [15:0] ctl);
    wr(A_LK, KEY);
    wr(A_LO, ld[15:0]);
    wr(A_HI, ld[31:16]);
    wr(A_CTL, ctl);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(A_LO, d);  chk(d, 0, "R1 load lo");
    rd(A_HI, d);  chk(d, 0, "R1 load hi");
    rd(A_CTL, d); chk(d, 0, "R1 ctrl");
    rd(A_LK, d);  chk(d, 1, "R1 lock");
    chk(reset_req, 0, "R1 req");

    // R2 key values
    wr(A_LK, KEY);     rd(A_LK, d); chk(d, 0, "R2 unlock");
    wr(A_LK, ~KEY);    rd(A_LK, d); chk(d, 1, "R2 inverse relock");
    wr(A_LK, KEY);     wr(A_LK, 16'h1234); rd(A_LK, d); chk(d, 1, "R2 other relock");
    wr(A_LK, 16'hE550); rd(A_LK, d); chk(d, 1, "R2 near key");

    // R5 control fields
    wr(A_LK, KEY); wr(A_CTL, 16'hFFF5); rd(A_CTL, d); chk(d, 16'h0000, "R5 other bits");
    wr(A_CTL, 16'h000E); rd(A_CTL, d); chk(d, 16'h000A, "R5 run rsten new");
    wr(A_CTL, 16'h0000);

    // R3 locked writes ignored, reads kept
    wr(A_LO, 16'h0007); wr(A_HI, 16'h0003); wr(A_LK, ~KEY);
    wr(A_LO, 16'h0055); wr(A_HI, 16'h0066); wr(A_CTL, 16'h000A);
    rd(A_LO, d); chk(d, 16'h0007, "R3 lo kept");
    rd(A_HI, d); chk(d, 16'h0003, "R3 hi kept");
    rd(A_CTL, d); chk(d, 0, "R3 ctrl kept");
    tick_n(10); chk(reset_req, 0, "R3 not started");

    // R10 interface disabled
    intf_enable = 1'b0;
    rd(A_LO, d); chk(d, 0, "R10 rdata zero");
    wr(A_LK, KEY);
    intf_enable = 1'b1;
    rd(A_LK, d); chk(d, 1, "R10 lock write ignored");

    // R6 sweep of small loads
    for (int n = 0; n <= 12; n++) begin
      int need;
      do_reset();
      arm(n, 16'h000A);
      need = (n == 0) ? 1 : n;
      if (need > 1) begin
        tick_n(need - 1);
        chk(reset_req, 0, $sformatf("R6 load %0d early", n));
      end
      tick_n(1);
      chk(reset_req, 1, $sformatf("R6 load %0d expire", n));
    end

    // R7 sticky request
    wr(A_CTL, 16'h0000); wr(A_LK, ~KEY); tick_n(2);
    chk(reset_req, 1, "R7 sticky");
    do_reset(); chk(reset_req, 0, "R7 cleared by reset");

    // R4 high half
    do_reset();
    arm(32'h0001_0000, 16'h000A);
    tick_n(65535); chk(reset_req, 0, "R4 high half early");
    tick_n(1);     chk(reset_req, 1, "R4 high half expire");

    // R8 expiry without reset-enable
    do_reset();
    arm(3, 16'h0002);
    tick_n(5); chk(reset_req, 0, "R8 no request");
    wr(A_CTL, 16'h000A);
    chk(reset_req, 0, "R8 before tick");
    tick_n(1); chk(reset_req, 1, "R8 late arm");

    // R11 reload restarts window
    do_reset();
    arm(5, 16'h000A);
    tick_n(3);
    wr(A_CTL, 16'h000E);
    tick_n(4); chk(reset_req, 0, "R11 reloaded");
    tick_n(1); chk(reset_req, 1, "R11 expire");

    // R9 work enable gating
    do_reset();
    arm(2, 16'h000A);
    work_enable = 1'b0;
    tick_n(6); chk(reset_req, 0, "R9 gated");
    work_enable = 1'b1;
    tick_n(1); chk(reset_req, 0, "R9 one tick");
    tick_n(1); chk(reset_req, 1, "R9 expire");

    // R12 run clear
    do_reset();
    arm(1, 16'h0008);
    tick_n(4); chk(reset_req, 0, "R12 not running");
    wr(A_CTL, 16'h000A);
    tick_n(1); chk(reset_req, 1, "R12 after run");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule